// File: doc/BRIEF.md
# Wear Deviation Monitor

The block keeps an 8-bit wear index for each of `N_CHUNKS` storage chunks and tracks the integer mean of all of them. A wear index only grows: 0 marks a fresh chunk and 255 marks a worn-out one. After each wear update, every chunk is compared against a band centred on the mean, with half-width set by an 8-bit threshold input. A chunk whose index falls outside that band produces one notification record, queued for a consumer on a valid/ready output.

Updates come in as a chunk index and a new value, with a valid/ready handshake. Accepting one update starts a rescan of all chunks in ascending index order, one chunk per cycle. The block takes no other update until that rescan has finished. Each record carries four fields:
- a 64-bit sequence number that starts at one;
- the chunk index;
- a 16-bit state word;
- an 8-bit scope mask.

When the queue is full, new records are dropped and a sticky overflow output goes high.

Top module: `wear_deviation_monitor`

## Requirements
- R1: After a synchronous active-high reset, every stored index and the mean are zero, no record is offered (`evt_valid_o` low), `overflow_o` is low and `upd_ready_o` is high.
- R2: An accepted update stores the larger of the stored index and the new value. A lower value leaves the stored index, and therefore the mean, unchanged.
- R3: The mean is the sum of all stored indices divided by `N_CHUNKS`, rounded down. `N_CHUNKS` is a power of two.
- R4: A chunk raises a record only on the rescan in which it first becomes out of band. It raises no further record until a later rescan finds it back in band. This holds even when its first record was dropped.
- R5: Record fields: the sequence number is one for the first queued record and increases by one for each queued record, with no gap for dropped ones. `evt_state_o` is 16'h0100, where bit 8 means out of band (bit 4 would mean refreshed; bits 3..0 error-rate levels unrecoverable, high, medium, low). `evt_mask_o` is 8'h02, where bit 1 means chunk scope (bit 0 block scope, bit 2 parallel-unit scope).
- R6: Within one rescan, records are queued in ascending chunk index order.
- R7: After an update is accepted, `upd_ready_o` stays low for exactly `N_CHUNKS` cycles and then returns high. An update offered while `upd_ready_o` is low is ignored.
- R8: The queue holds `FIFO_DEPTH` records. A record raised while the queue is full, judged on its occupancy before any same-cycle pop, is dropped and sets `overflow_o`. `overflow_o` stays high until reset.
- R9: While `evt_valid_o` is high and `evt_ready_i` is low, the offered record stays unchanged. Records leave in the order they were queued.
- R10: A chunk is out of band only when its index is strictly greater than mean+threshold or strictly less than mean−threshold. Both limits are computed without wrap, and an index equal to either limit is in band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh_i | input | 8 | Half-width of the allowed band around the mean |
| upd_valid_i | input | 1 | Wear update offered |
| upd_chunk_i | input | $clog2(N_CHUNKS) | Chunk index of the update |
| upd_wear_i | input | 8 | New wear index value |
| upd_ready_o | output | 1 | Update can be accepted (no rescan running) |
| evt_valid_o | output | 1 | A notification record is offered |
| evt_ready_i | input | 1 | Consumer takes the offered record |
| evt_count_o | output | 64 | Sequence number of the record |
| evt_chunk_o | output | $clog2(N_CHUNKS) | Chunk that left the band |
| evt_state_o | output | 16 | State word of the record |
| evt_mask_o | output | 8 | Scope mask of the record |
| overflow_o | output | 1 | Sticky: a record was dropped |

## Verification
The assertions check, on every cycle:
- the sum never shrinks on an update;
- the rescan index steps by one;
- the update handshake closes for the cycle after an accept;
- the offered record stays unchanged while stalled;
- consecutive popped records carry consecutive sequence numbers;
- queue occupancy stays bounded and the overflow flag stays set once raised.

Other behaviours can only be shown by the bench scenarios against its own model:
- which chunks fall out of band;
- the exact band limits;
- that a lowered wear value is ignored;
- that a chunk re-arms only after returning to band;
- that records raised against a full queue are dropped.

// File: rtl/wlm_pkg.sv
package wlm_pkg;
    localparam int WEAR_W  = 8;
    localparam int CNT_W   = 64;
    localparam int STATE_W = 16;
    localparam int MASK_W  = 8;

    // State word bit positions
    localparam int ST_BAND_BIT    = 8;
    localparam int ST_REFRESH_BIT = 4;
    localparam int ST_ERR_UNREC   = 3;
    localparam int ST_ERR_HIGH    = 2;
    localparam int ST_ERR_MED     = 1;
    localparam int ST_ERR_LOW     = 0;

    // Scope mask bit positions
    localparam int SCOPE_BLOCK_BIT = 0;
    localparam int SCOPE_CHUNK_BIT = 1;
    localparam int SCOPE_PU_BIT    = 2;

    typedef logic [WEAR_W-1:0] wear_t;

    typedef struct packed {
        logic [CNT_W-1:0]   seq;
        logic [STATE_W-1:0] state;
        logic [MASK_W-1:0]  scope;
    } note_t;

    typedef enum logic {PH_IDLE, PH_SCAN} phase_e;

    // True when w lies strictly outside [avg-thr, avg+thr], evaluated one bit wider
    function automatic logic beyond_band(wear_t w, wear_t avg, wear_t thr);
        logic [WEAR_W:0] upper;
        logic [WEAR_W:0] lifted;
        upper  = {1'b0, avg} + {1'b0, thr};
        lifted = {1'b0, w} + {1'b0, thr};
        return ({1'b0, w} > upper) || (lifted < {1'b0, avg});
    endfunction

    function automatic note_t wear_note(logic [CNT_W-1:0] seq);
        note_t n;
        n.seq   = seq;
        n.state = '0;
        n.state[ST_BAND_BIT] = 1'b1;
        n.scope = '0;
        n.scope[SCOPE_CHUNK_BIT] = 1'b1;
        return n;
    endfunction
endpackage

// File: rtl/wlm_wear_bank.sv
module wlm_wear_bank
    import wlm_pkg::*;
#(
    parameter int N_CHUNKS = 16,
    localparam int IDX_W = (N_CHUNKS > 1) ? $clog2(N_CHUNKS) : 1,
    localparam int SUM_W = IDX_W + WEAR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  wear_t            wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output wear_t            rd_val,
    output wear_t            avg
);
    wear_t            bank [N_CHUNKS];
    logic [SUM_W-1:0] total;
    wear_t            kept;

    // Wear only grows: keep the larger of stored and offered values
    always_comb kept = (wr_val > bank[wr_idx]) ? wr_val : bank[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            total <= '0;
            for (int i = 0; i < N_CHUNKS; i++) bank[i] <= '0;
        end else if (wr_en) begin
            bank[wr_idx] <= kept;
            total        <= total - SUM_W'(bank[wr_idx]) + SUM_W'(kept);
        end
    end

    assign rd_val = bank[rd_idx];
    assign avg    = total[SUM_W-1:IDX_W];

    // R2: the population sum never shrinks on an update
    assert_sum_monotone_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> total >= $past(total));
endmodule

// File: rtl/wlm_scan_ctrl.sv
module wlm_scan_ctrl
    import wlm_pkg::*;
#(
    parameter int N_CHUNKS = 16,
    localparam int IDX_W = (N_CHUNKS > 1) ? $clog2(N_CHUNKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  wear_t            rd_wear,
    input  wear_t            avg,
    input  wear_t            thr,
    output logic             busy,
    output logic [IDX_W-1:0] scan_idx,
    output logic             hit
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHUNKS - 1);

    phase_e              phase;
    logic [IDX_W-1:0]    idx;
    logic [N_CHUNKS-1:0] flagged;
    logic                outside;

    always_comb outside = beyond_band(rd_wear, avg, thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            flagged <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SCAN;
                        idx   <= '0;
                    end
                end
                PH_SCAN: begin
                    flagged[idx] <= outside;
                    idx          <= idx + 1'b1;
                    if (idx == LAST_IDX) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase == PH_SCAN);
    assign scan_idx = idx;
    assign hit      = (phase == PH_SCAN) && outside && !flagged[idx];

    // R6: chunks are visited in ascending order, one per cycle
    assert_scan_step_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SCAN && idx != LAST_IDX) |=> (phase == PH_SCAN && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/wlm_note_fifo.sv
module wlm_note_fifo #(
    parameter int WIDTH = 80,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic             full,
    output logic             valid,
    output logic [WIDTH-1:0] dout,
    output logic             overflow
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [AW:0]      level;
    logic             do_push, do_pop;

    assign full    = (level == (AW+1)'(DEPTH));
    assign valid   = (level != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr      <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
            if (push && full) overflow <= 1'b1;
        end
    end

    // R8: occupancy stays within the queue depth
    assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
        level <= (AW+1)'(DEPTH));
    // R8: overflow is sticky until reset
    assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

// File: rtl/wear_deviation_monitor.sv
module wear_deviation_monitor
    import wlm_pkg::*;
#(
    parameter int N_CHUNKS   = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int IDX_W   = (N_CHUNKS > 1) ? $clog2(N_CHUNKS) : 1,
    localparam int ENTRY_W = IDX_W + $bits(note_t)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WEAR_W-1:0]  thresh_i,
    input  logic               upd_valid_i,
    input  logic [IDX_W-1:0]   upd_chunk_i,
    input  logic [WEAR_W-1:0]  upd_wear_i,
    output logic               upd_ready_o,
    output logic               evt_valid_o,
    input  logic               evt_ready_i,
    output logic [CNT_W-1:0]   evt_count_o,
    output logic [IDX_W-1:0]   evt_chunk_o,
    output logic [STATE_W-1:0] evt_state_o,
    output logic [MASK_W-1:0]  evt_mask_o,
    output logic               overflow_o
);
    logic             accept, busy, hit, q_full;
    logic [IDX_W-1:0] scan_idx;
    wear_t            rd_wear, avg;
    logic [CNT_W-1:0] issued;
    logic [ENTRY_W-1:0] push_entry, head_entry;
    note_t            head_note;

    assign upd_ready_o = !busy;
    assign accept      = upd_valid_i && upd_ready_o;

    wlm_wear_bank #(.N_CHUNKS(N_CHUNKS)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(accept), .wr_idx(upd_chunk_i), .wr_val(upd_wear_i),
        .rd_idx(scan_idx), .rd_val(rd_wear), .avg(avg)
    );

    wlm_scan_ctrl #(.N_CHUNKS(N_CHUNKS)) u_scan (
        .clk(clk), .rst(rst), .start(accept),
        .rd_wear(rd_wear), .avg(avg), .thr(thresh_i),
        .busy(busy), .scan_idx(scan_idx), .hit(hit)
    );

    // Sequence numbers are consumed only by records that enter the queue
    always_ff @(posedge clk) begin
        if (rst)               issued <= '0;
        else if (hit && !q_full) issued <= issued + 1'b1;
    end

    assign push_entry = {scan_idx, wear_note(issued + 1'b1)};

    wlm_note_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(hit), .din(push_entry),
        .pop(evt_ready_i), .full(q_full),
        .valid(evt_valid_o), .dout(head_entry), .overflow(overflow_o)
    );

    assign head_note   = head_entry[$bits(note_t)-1:0];
    assign evt_chunk_o = head_entry[ENTRY_W-1:$bits(note_t)];
    assign evt_count_o = head_note.seq;
    assign evt_state_o = head_note.state;
    assign evt_mask_o  = head_note.scope;

    // R7: an accepted update closes the update port on the next cycle
    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && upd_ready_o) |=> !upd_ready_o);
    // R9: a stalled record is held unchanged
    assert_hold_record_R9: assert property (@(posedge clk) disable iff (rst)
        (evt_valid_o && !evt_ready_i) |=> (evt_valid_o && $stable(evt_count_o) && $stable(evt_chunk_o)));
    // R5: records leave with consecutive sequence numbers
    assert_seq_contiguous_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_valid_o && evt_ready_i) |=> (!evt_valid_o || evt_count_o == $past(evt_count_o) + 1'b1));
endmodule

// File: tb/wear_deviation_monitor_bench.sv
module wear_deviation_monitor_bench;
    localparam int NCH   = 8;
    localparam int DEPTH = 4;
    localparam int IW    = $clog2(NCH);
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    thresh = '0;
    logic          upd_valid = 1'b0;
    logic [IW-1:0] upd_chunk = '0;
    logic [7:0]    upd_wear = '0;
    logic          upd_ready;
    logic          evt_valid;
    logic          evt_ready = 1'b0;
    logic [63:0]   evt_count;
    logic [IW-1:0] evt_chunk;
    logic [15:0]   evt_state;
    logic [7:0]    evt_mask;
    logic          ovf;

    always #5 clk = ~clk;

    wear_deviation_monitor #(.N_CHUNKS(NCH), .FIFO_DEPTH(DEPTH)) u_wear_deviation_monitor (
        .clk(clk), .rst(rst), .thresh_i(thresh),
        .upd_valid_i(upd_valid), .upd_chunk_i(upd_chunk), .upd_wear_i(upd_wear),
        .upd_ready_o(upd_ready),
        .evt_valid_o(evt_valid), .evt_ready_i(evt_ready),
        .evt_count_o(evt_count), .evt_chunk_o(evt_chunk),
        .evt_state_o(evt_state), .evt_mask_o(evt_mask),
        .overflow_o(ovf)
    );

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    // Behavioural reference model
    typedef struct { int chunk; longint cnt; } exp_t;
    exp_t   q[$];
    int     m_wear [NCH];
    bit     m_flag [NCH];
    longint m_cnt;
    bit     m_ovf;
    int     thr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < NCH; i++) begin m_wear[i] = 0; m_flag[i] = 0; end
        m_cnt = 0; m_ovf = 0; q.delete();
    endfunction

    function automatic void model_update(int c, int w);
        int sum = 0;
        int a;
        if (w > m_wear[c]) m_wear[c] = w;
        for (int i = 0; i < NCH; i++) sum += m_wear[i];
        a = sum / NCH;
        for (int i = 0; i < NCH; i++) begin
            if (m_wear[i] > a + thr || m_wear[i] < a - thr) begin
                if (!m_flag[i]) begin
                    m_flag[i] = 1;
                    if (q.size() < DEPTH) begin
                        exp_t e;
                        m_cnt++;
                        e.chunk = i; e.cnt = m_cnt;
                        q.push_back(e);
                    end else m_ovf = 1;
                end
            end else m_flag[i] = 0;
        end
    endfunction

    // Per-clock comparison against the model while no rescan runs
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            chk(upd_ready == 1'b1, "R7", "ready while idle", upd_ready, 1);
            chk(evt_valid == (q.size() != 0), "R9", "record offered", evt_valid, q.size() != 0);
            chk(ovf == m_ovf, "R8", "overflow flag", ovf, m_ovf);
            if (evt_valid && q.size() != 0) begin
                chk(evt_chunk == q[0].chunk, "R6", "record chunk", evt_chunk, q[0].chunk);
                chk(evt_count == q[0].cnt, "R5", "record sequence", evt_count, q[0].cnt);
                chk(evt_state == 16'h0100, "R5", "state word", evt_state, 16'h0100);
                chk(evt_mask == 8'h02, "R5", "scope mask", evt_mask, 8'h02);
            end
        end
    end

    task automatic do_reset();
        mon_en = 1'b0;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk(upd_ready == 1'b1, "R1", "ready after reset", upd_ready, 1);
        chk(evt_valid == 1'b0, "R1", "no record after reset", evt_valid, 0);
        chk(ovf == 1'b0, "R1", "overflow after reset", ovf, 0);
        mon_en = 1'b1;
    endtask

    // Offer one update; optionally offer a stray update during the rescan
    task automatic do_update(input int c, input int w, input bit poke);
        @(negedge clk);
        thresh = 8'(thr); upd_valid = 1'b1; upd_chunk = IW'(c); upd_wear = 8'(w);
        @(posedge clk);
        mon_en = 1'b0;
        model_update(c, w);
        #1 upd_valid = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            @(negedge clk);
            chk(upd_ready == 1'b0, "R7", "ready low during rescan", upd_ready, 0);
            if (poke && k == 1) begin upd_valid = 1'b1; upd_chunk = IW'(5); upd_wear = 8'd255; end
            if (poke && k == 2) upd_valid = 1'b0;
        end
        @(negedge clk);
        chk(upd_ready == 1'b1, "R7", "ready back after N cycles", upd_ready, 1);
        mon_en = 1'b1;
    endtask

    task automatic pop_one();
        repeat (3) @(negedge clk);   // stall: monitor checks the head is held (R9)
        evt_ready = 1'b1;
        @(posedge clk);
        void'(q.pop_front());
        #1 evt_ready = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) pop_one();
        @(negedge clk);
        chk(evt_valid == 1'b0, "R9", "queue empty after drain", evt_valid, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R7 watchdog expired: actual %0d expected %0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();                                   // R1

        // R2/R3: single chunk leaves the band, lower value ignored
        thr = 10;
        do_update(0, 40, 1'b0);                       // mean 5: chunk 0 out, record #1
        chk(q.size() == 1, "R3", "one record expected", q.size(), 1);
        drain();
        do_update(0, 8, 1'b0);                        // R2: lower value ignored
        do_update(0, 41, 1'b0);                       // R4: still out, no repeat
        chk(evt_valid == 1'b0, "R2", "no record after ignored lowering", evt_valid, 0);

        // R10: band limits are inclusive
        do_reset();
        thr = 3;
        do_update(1, 3, 1'b0);                        // equal to mean+thr: in band
        chk(evt_valid == 1'b0, "R10", "upper limit in band", evt_valid, 0);
        do_update(1, 4, 1'b0);                        // one above: out
        drain();
        thr = 40;
        do_update(2, 32, 1'b0);                       // mean 4, all in band
        chk(evt_valid == 1'b0, "R10", "wide band quiet", evt_valid, 0);
        thr = 4;
        do_update(3, 0, 1'b1);                        // zeros sit on lower limit; stray update ignored (R7)
        chk(q.size() == 1, "R10", "only chunk 2 out", q.size(), 1);

        // R6/R8: flood of records, queue overflows
        thr = 3;
        do_update(3, 0, 1'b0);
        chk(q.size() == DEPTH, "R8", "queue full", q.size(), DEPTH);
        drain();
        do_update(3, 0, 1'b0);                        // R4: all still flagged, even dropped ones
        chk(evt_valid == 1'b0, "R4", "no repeat records", evt_valid, 0);
        chk(ovf == 1'b1, "R8", "overflow sticky", ovf, 1);

        // R4: re-arm after returning to band
        thr = 40;
        do_update(3, 0, 1'b0);
        thr = 3;
        do_update(4, 0, 1'b0);
        drain();

        do_reset();                                   // R1: overflow cleared
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule